// File: doc/BRIEF.md
# E1-to-T1 Timeslot Rate Mapper

This block takes a framed serial stream arriving at the 2.048 Mb/s rate, one bit per clock, organised as 32 eight-bit timeslots per 256-bit frame, and carries a T1-format frame on it. That frame has one framing bit followed by 24 eight-bit channels. The output is a serial bit with a valid strobe. Of every 256 input bit times, 193 are marked valid and the rest are gaps. The downstream logic keeps the valid bits and ignores the data in the gaps. An output frame-start strobe marks the framing bit.

A two-bit mode input chooses which 24 of the 32 input timeslots become channels, and where the framing bit comes from. Three mapping rules are available. A fourth value passes a native 1.544 Mb/s stream straight through. In the first rule, the framing bit comes from the previous input frame. The block holds that bit across the frame boundary and sends it in the position where timeslot 0 ends, so the output never needs buffering beyond one register stage. The mode is taken at each input frame pulse.

Top module: `e1_t1_mapper`

## Requirements
- R1: After reset, `out_valid`, `out_fs` and `out_bit` are 0, and both strobes stay 0 until the first `in_fs` pulse has been seen.
- R2: Each output appears on the clock edge after its input bit. In mapping modes 0, 1 and 2, the framing bit goes out at the bit-time of input timeslot 0 bit index 7 (the eighth bit, position 7 of 0..255), with `out_fs` high. Exactly 193 of the 256 bit-times of a frame are valid, and the frame-pulse bit-time (position 0) is always a gap.
- R3: Mode 0 (`2'b00`) uses input timeslots 1..15 and 17..25 as channels. Timeslots 0 (except the framing position), 16, 26 and 27..31 are gaps.
- R4: In mode 0, the framing bit of a frame is the bit at position 0 of timeslot 26 in the previous input frame. That bit is captured only while mode 0 is in effect. Its store resets to 0, so the first mode-0 frame after reset sends a framing bit of 0.
- R5: Mode 1 (`2'b01`) takes the framing bit from timeslot 0 bit index 7 of the same frame. It uses every timeslot whose number is not a multiple of 4 (1..3, 5..7, …, 29..31) as a channel.
- R6: Mode 2 (`2'b10`) takes the framing bit from timeslot 0 bit index 7 of the same frame. It uses timeslots 1..24 as channels, and timeslots 25..31 are gaps.
- R7: Mode 3 (`2'b11`) marks every input bit valid and copies it to `out_bit`. `out_fs` follows `in_fs` one cycle later.
- R8: The mode is sampled only on a clock where `in_fs` is high. A change of `mode` in the middle of a frame has no effect until the next frame pulse.
- R9: An `in_fs` pulse sets the current bit to position 0 at any point in the frame. Without a pulse, the position wraps from 255 to 0 by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one input bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_bit | input | 1 | Serial input data |
| in_fs | input | 1 | Input frame pulse, high on bit 0 of timeslot 0 (or on the framing bit in mode 3) |
| mode | input | 2 | Mapping rule: 0, 1, 2 as in R3/R5/R6, 3 pass-through |
| out_bit | output | 1 | Serial T1-format data, meaningful only when `out_valid` is high |
| out_valid | output | 1 | High on bit-times that carry a T1 bit |
| out_fs | output | 1 | High on the framing bit of each output frame |

## Verification
The bench builds the block with its default geometry of 32 timeslots of 8 bits. With that geometry, every position of the 256-bit frame is exercised, including the wrap from 255 to 0 and the timeslot-26 capture that feeds the next frame. A behavioural model lists each mode's channel sources and predicts strobes and data on every clock. The stimulus runs random frames in all four modes, changes the mode in the middle of a frame, sends an early frame pulse, and lets the position wrap without a pulse. The valid count of 193 per frame is counted at the output.

// File: rtl/e1t1_map_pkg.sv
// Package: shared mode encoding and fixed frame positions for the mapper.
// Assumes 8-bit timeslots in a 32-slot frame for the slot-number rules.
package e1t1_map_pkg;

    typedef enum logic [1:0] {
        MAP_G802  = 2'b00,
        MAP_FILL4 = 2'b01,
        MAP_CONT  = 2'b10,
        MAP_THRU  = 2'b11
    } map_mode_e;

    // Timeslot whose first bit feeds the next frame's framing bit in mode 0
    localparam int G802_FSRC_SLOT = 26;
    // Timeslot-0 bit index that carries the framing bit
    localparam int FBIT_INDEX     = 7;
    // Number of T1 channels produced
    localparam int T1_CHANNELS    = 24;

endpackage

// File: rtl/frame_pos_counter.sv
// frame_pos_counter: tracks the bit position inside the input frame.
// A frame pulse forces position 0 on its own clock; otherwise the count
// wraps after SLOTS*SLOT_BITS bits. 'active' is low until the first pulse.
// Assumes SLOTS*SLOT_BITS is at least 2.
module frame_pos_counter #(
    parameter int SLOTS     = 32,
    parameter int SLOT_BITS = 8,
    localparam int FRAME_BITS = SLOTS * SLOT_BITS,
    localparam int POS_W      = $clog2(FRAME_BITS),
    localparam int SLOT_W     = $clog2(SLOTS),
    localparam int BIT_W      = $clog2(SLOT_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_fs,
    output logic [SLOT_W-1:0] slot,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              active
);

    logic [POS_W-1:0] cnt_q;
    logic [POS_W-1:0] pos;
    logic             seen_q;

    // current position: the frame pulse overrides the running count
    always_comb begin
        pos = in_fs ? '0 : cnt_q;
    end

    assign slot    = SLOT_W'(pos / POS_W'(SLOT_BITS));
    assign bit_idx = BIT_W'(pos % POS_W'(SLOT_BITS));
    assign active  = seen_q | in_fs;

    // advance the position and remember that a frame pulse has occurred
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            cnt_q  <= (pos == POS_W'(FRAME_BITS - 1)) ? '0 : pos + 1'b1;
            seen_q <= seen_q | in_fs;
        end
    end

endmodule

// File: rtl/frame_mode_latch.sv
// frame_mode_latch: holds the mapping mode for the whole frame.
// The mode input is taken only with the frame pulse and applies from
// that very bit; mid-frame changes wait for the next pulse.
module frame_mode_latch
    import e1t1_map_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_fs,
    input  logic [1:0] mode_in,
    output map_mode_e  mode_eff
);

    map_mode_e mode_q;

    // effective mode: new value on the pulse bit, held value elsewhere
    always_comb begin
        mode_eff = in_fs ? map_mode_e'(mode_in) : mode_q;
    end

    // register the mode at each frame pulse
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MAP_G802;
        else if (in_fs) mode_q <= map_mode_e'(mode_in);
    end

endmodule

// File: rtl/slot_selector.sv
// slot_selector: decides for one bit position whether it is the framing
// bit, a channel bit, or a gap, under the effective mode.
// Purely combinational; assumes a 32-slot frame for the slot rules.
module slot_selector
    import e1t1_map_pkg::*;
#(
    parameter int SLOTS     = 32,
    parameter int SLOT_BITS = 8,
    localparam int SLOT_W   = $clog2(SLOTS),
    localparam int BIT_W    = $clog2(SLOT_BITS)
) (
    input  map_mode_e         mode_eff,
    input  logic [SLOT_W-1:0] slot,
    input  logic [BIT_W-1:0]  bit_idx,
    output logic              is_fbit,
    output logic              is_chan,
    output logic              grab_fsrc
);

    logic f_pos;

    assign f_pos = (slot == '0) && (bit_idx == BIT_W'(FBIT_INDEX));

    // classify the position under the chosen mapping rule
    always_comb begin
        is_fbit   = 1'b0;
        is_chan   = 1'b0;
        grab_fsrc = 1'b0;
        unique case (mode_eff)
            MAP_G802: begin
                is_fbit   = f_pos;
                is_chan   = ((slot >= SLOT_W'(1))  && (slot <= SLOT_W'(15))) ||
                            ((slot >= SLOT_W'(17)) && (slot <= SLOT_W'(25)));
                grab_fsrc = (slot == SLOT_W'(G802_FSRC_SLOT)) && (bit_idx == '0);
            end
            MAP_FILL4: begin
                is_fbit = f_pos;
                is_chan = (slot[1:0] != 2'b00);
            end
            MAP_CONT: begin
                is_fbit = f_pos;
                is_chan = (slot >= SLOT_W'(1)) && (slot <= SLOT_W'(T1_CHANNELS));
            end
            MAP_THRU: begin
                is_chan = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/fbit_store.sv
// fbit_store: one-bit store carrying the mode-0 framing bit from one
// frame into the next. Resets to 0; loads only when told to.
module fbit_store (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic din,
    output logic held
);

    // capture the source bit on request, keep it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) held <= 1'b0;
        else if (load) held <= din;
    end

endmodule

// File: rtl/e1_t1_mapper.sv
// e1_t1_mapper: carries a 193-bit T1 frame on a 256-bit E1-rate stream.
// One bit in per clock, one registered bit out the following clock, with
// a valid strobe for kept bits and a frame strobe on the framing bit.
// Assumes in_fs is high on position 0 of timeslot 0 (framing bit in
// pass-through mode) and that no output is produced before the first pulse.
module e1_t1_mapper
    import e1t1_map_pkg::*;
#(
    parameter int SLOTS     = 32,
    parameter int SLOT_BITS = 8,
    localparam int SLOT_W   = $clog2(SLOTS),
    localparam int BIT_W    = $clog2(SLOT_BITS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_bit,
    input  logic       in_fs,
    input  logic [1:0] mode,
    output logic       out_bit,
    output logic       out_valid,
    output logic       out_fs
);

    logic [SLOT_W-1:0] slot;
    logic [BIT_W-1:0]  bit_idx;
    logic              active;
    map_mode_e         mode_eff;
    logic              is_fbit;
    logic              is_chan;
    logic              grab_fsrc;
    logic              fbit_held;
    logic              thru;

    frame_pos_counter #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_fs   (in_fs),
        .slot    (slot),
        .bit_idx (bit_idx),
        .active  (active)
    );

    frame_mode_latch u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_fs    (in_fs),
        .mode_in  (mode),
        .mode_eff (mode_eff)
    );

    slot_selector #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_sel (
        .mode_eff  (mode_eff),
        .slot      (slot),
        .bit_idx   (bit_idx),
        .is_fbit   (is_fbit),
        .is_chan   (is_chan),
        .grab_fsrc (grab_fsrc)
    );

    fbit_store u_fst (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (active & grab_fsrc),
        .din   (in_bit),
        .held  (fbit_held)
    );

    assign thru = (mode_eff == MAP_THRU);

    // register the mapped bit and its strobes one clock after the input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_bit   <= 1'b0;
            out_valid <= 1'b0;
            out_fs    <= 1'b0;
        end else begin
            out_valid <= active & (is_fbit | is_chan);
            out_fs    <= active & (thru ? in_fs : is_fbit);
            out_bit   <= ((mode_eff == MAP_G802) && is_fbit) ? fbit_held : in_bit;
        end
    end

endmodule

// File: rtl/e1_t1_mapper_chk.sv
// e1_t1_mapper_chk: port-level properties of the mapper, bound to it.
// Keeps its own record of whether a frame pulse has occurred.
module e1_t1_mapper_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_bit,
    input logic       in_fs,
    input logic [1:0] mode,
    input logic       out_bit,
    input logic       out_valid,
    input logic       out_fs
);

    logic pulse_seen_q;

    // note the first frame pulse since reset
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_seen_q <= 1'b0;
        else if (in_fs) pulse_seen_q <= 1'b1;
    end

    assert_quiet_before_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_seen_q |-> (!out_valid && !out_fs));

    assert_fs_is_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_fs |-> out_valid);

    assert_pulse_bit_is_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fs && mode != 2'b11) |=> !out_valid);

    assert_thru_copies_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fs && mode == 2'b11) |=> (out_valid && out_fs && out_bit == $past(in_bit)));

endmodule

bind e1_t1_mapper e1_t1_mapper_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_bit    (in_bit),
    .in_fs     (in_fs),
    .mode      (mode),
    .out_bit   (out_bit),
    .out_valid (out_valid),
    .out_fs    (out_fs)
);

// File: tb/tb_e1_t1_mapper.sv
module tb_e1_t1_mapper;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_bit = 1'b0;
    logic       in_fs = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       out_bit;
    logic       out_valid;
    logic       out_fs;

    int checks = 0;
    int errors = 0;

    // reference model state
    int    m_pos = 0;
    bit    m_locked = 0;
    int    m_mode = 0;
    bit    m_fhold = 0;
    bit    exp_v = 0;
    bit    exp_b = 0;
    bit    exp_f = 0;
    string exp_tag = "R1";
    string cur_tag = "";
    int    vcnt = 0;

    e1_t1_mapper dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_bit    (in_bit),
        .in_fs     (in_fs),
        .mode      (mode),
        .out_bit   (out_bit),
        .out_valid (out_valid),
        .out_fs    (out_fs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // does timeslot ts feed some channel under mapping rule m
    function automatic bit slot_used(int m, int ts);
        for (int ch = 0; ch < 24; ch++) begin
            int src;
            if (m == 0)      src = (ch < 15) ? ch + 1 : ch + 2;
            else if (m == 1) src = ch + ch / 3 + 1;
            else             src = ch + 1;
            if (src == ts) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic model(input bit b, input bit f, input int mi);
        int p, m, ts, bi;
        p = f ? 0 : m_pos;
        if (f) begin m_locked = 1; m_mode = mi; end
        m = m_mode;
        ts = p / 8; bi = p % 8;
        exp_v = 0; exp_f = 0; exp_b = b;
        if (!m_locked) exp_tag = "R1";
        else if (m == 3) begin
            exp_v = 1; exp_f = f; exp_tag = "R7";
        end else if (ts == 0 && bi == 7) begin
            exp_v = 1; exp_f = 1;
            exp_b = (m == 0) ? m_fhold : b;
            exp_tag = (m == 0) ? "R4" : "R2";
        end else begin
            exp_v = slot_used(m, ts);
            exp_tag = (m == 0) ? "R3" : (m == 1) ? "R5" : "R6";
        end
        if (cur_tag != "") exp_tag = cur_tag;
        if (m_locked && m == 0 && p == 26 * 8) m_fhold = b;
        m_pos = (p + 1) % 256;
    endtask

    task automatic check_out();
        checks++;
        if (out_valid !== exp_v || out_fs !== exp_f || (exp_v && out_bit !== exp_b)) begin
            errors++;
            $display("FAIL %s: actual v=%b fs=%b d=%b expected v=%b fs=%b d=%b",
                     exp_tag, out_valid, out_fs, out_bit, exp_v, exp_f, exp_b);
        end
        if (out_valid === 1'b1) vcnt++;
    endtask

    task automatic step(input bit b, input bit f, input int m);
        @(negedge clk);
        check_out();
        in_bit = b; in_fs = f; mode = 2'(m);
        model(b, f, m);
    endtask

    task automatic run_frame(input int m, input int n, input bit with_fs);
        for (int i = 0; i < n; i++) begin
            step(1'($urandom % 2), with_fs && i == 0, m);
            if (i == 0) vcnt = 0;
        end
    endtask

    task automatic check_count(input string tag, input int m);
        step(1'b0, 1'b0, m);
        checks++;
        if (vcnt - (out_valid === 1'b1 ? 1 : 0) != 193 && vcnt != 193) begin
            errors++;
            $display("FAIL %s: valid bits per frame actual=%0d expected=193", tag, vcnt);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_fs !== 1'b0 || out_bit !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset outputs actual=%b%b%b expected=000", out_valid, out_fs, out_bit);
        end
        rst_n = 1'b1;
        // R1: random data with no frame pulse stays silent
        run_frame(0, 20, 1'b0);

        // R3, R4: G.802 frames; first framing bit is the reset value 0
        run_frame(0, 256, 1'b1);
        check_count("R2", 0);
        run_frame(0, 256, 1'b1);
        run_frame(0, 256, 1'b1);
        // R5: filler every fourth slot
        run_frame(1, 256, 1'b1);
        check_count("R2", 1);
        run_frame(1, 256, 1'b1);
        // R6: continuous slots
        run_frame(2, 256, 1'b1);
        check_count("R2", 2);
        run_frame(2, 256, 1'b1);

        // R8: mode changes mid-frame; takes effect at the next pulse
        cur_tag = "R8";
        for (int i = 0; i < 256; i++)
            step(1'($urandom % 2), i == 0, (i < 100) ? 0 : 2);
        run_frame(2, 256, 1'b1);
        cur_tag = "";

        // R9: early pulse realigns, then free-running wrap without pulse
        cur_tag = "R9";
        run_frame(1, 50, 1'b1);
        run_frame(1, 256, 1'b1);
        run_frame(1, 256, 1'b0);
        run_frame(1, 256, 1'b0);
        cur_tag = "";

        // R7: pass-through frames of 193 bits
        run_frame(3, 193, 1'b1);
        run_frame(3, 193, 1'b1);
        run_frame(3, 193, 1'b1);

        // back to G.802 to exercise the carried framing bit after mode change
        run_frame(0, 256, 1'b1);
        run_frame(0, 256, 1'b1);
        step(1'b0, 1'b0, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule